// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error Flags

This block receives asynchronous serial frames from an RX line that has already been brought into the clock domain. A baud tick arriving at sixteen times the bit rate drives the sampling. Each bit is resolved by a majority vote over the three samples at the centre of the bit cell. A frame carries 8 data bits, least significant bit first. An optional parity bit follows the data, with even or odd sense. The frame ends with one or two stop bits.

When a frame finishes, it is placed in a single holding register, and a buffer-full flag is raised. Four status bits travel with the held word: noise, parity error, framing error and overrun. A one-cycle read strobe consumes the word and clears the buffer-full flag and all four status bits together. If a frame completes while the buffer is still full, the new frame is discarded and the overrun flag is set.

Top module: `osr_uart_rx`

## Requirements
- R1: Sample numbers are counted within each bit cell. Sample 1 of the start bit is the first tick on which the line is low while idle, and every bit spans 16 samples. The bit value is the majority of samples 7, 8 and 9, so a single disagreeing sample in that window does not change the bit. Line values at other sample positions do not affect the bit.
- R2: If samples 7, 8 and 9 disagree for any bit of a stored frame, the noise flag is set with that frame. This applies to the start bit, the data bits, the parity bit and the stop bits.
- R3: When parity is enabled, a parity bit follows the 8 data bits. With `par_odd_i`=0 the data plus the parity bit must hold an even number of ones; with `par_odd_i`=1 they must hold an odd number. A mismatch sets the parity error flag.
- R4: With `two_stop_i`=0 there is one stop bit, and with `two_stop_i`=1 there are two. Any stop bit that resolves to 0 sets the framing error flag.
- R5: A completed frame is loaded into `data_o`, with the first data bit received in bit 0, and `full_o` goes high. This happens when the buffer is empty, or when a read strobe arrives in the same cycle.
- R6: If a frame completes while `full_o` is high and no read strobe is present, `data_o` and the held flags are left unchanged, the new frame is dropped, and `ovr_err_o` is set.
- R7: A read strobe without a completing frame clears `full_o`, `noise_err_o`, `par_err_o`, `frame_err_o` and `ovr_err_o`. A read strobe in the same cycle as a frame completion consumes the old word. In that case the new word is loaded, `full_o` stays high and no overrun is flagged.
- R8: Dropping `rx_en_i` while a frame is in progress abandons that frame. Nothing is stored, and `full_o` stays low.
- R9: The start bit is checked at its centre. If it resolves to 1, the receiver returns to idle and stores nothing.
- R10: After reset, `data_o` is 0 and all flag outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Synchronised serial line, idle high |
| tick16_i | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_en_i | input | 1 | Receiver enable |
| par_en_i | input | 1 | Parity bit present and checked |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop_i | input | 1 | 1 = two stop bits, 0 = one |
| rd_i | input | 1 | Read strobe for the held word |
| data_o | output | 8 | Held received word |
| full_o | output | 1 | Buffer holds an unread word |
| noise_err_o | output | 1 | Sample disagreement in the held frame |
| par_err_o | output | 1 | Parity mismatch in the held frame |
| frame_err_o | output | 1 | Stop bit resolved to 0 in the held frame |
| ovr_err_o | output | 1 | A frame was dropped because the buffer was full |

## Verification
A read strobe and a frame completion can fall in the same cycle. In that cycle one decision has to consume the old word and accept the new one. The bench provokes this by raising the read strobe in the clock right after the centre sample of the final stop bit. At that moment the scoreboard pops and checks the old word. On the next cycle it checks that the new word sits in the register, that the full flag is still set and that no overrun is reported.

// File: rtl/osr_rx_pkg.sv
package osr_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2
    } rx_state_e;

    typedef struct packed {
        logic noise;
        logic parity;
        logic framing;
    } frm_err_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic split3(input logic a, input logic b, input logic c);
        return (a != b) || (b != c);
    endfunction

endpackage

// File: rtl/osr_rx_voter.sv
module osr_rx_voter
    import osr_rx_pkg::*;
#(
    parameter int OSR = 16,
    parameter int CW  = $clog2(OSR + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic [CW-1:0] smp_i,
    input  logic          rx_i,
    output logic          rdy_o,
    output logic          val_o,
    output logic          noisy_o
);
    localparam logic [CW-1:0] SMP_A = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] SMP_B = CW'(OSR / 2);
    localparam logic [CW-1:0] SMP_C = CW'(OSR / 2 + 1);

    logic s_a, s_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_a <= 1'b1;
            s_b <= 1'b1;
        end else if (tick_i) begin
            if (smp_i == SMP_A) s_a <= rx_i;
            if (smp_i == SMP_B) s_b <= rx_i;
        end
    end

    // third sample is used live on the tick that takes it
    assign rdy_o   = tick_i && (smp_i == SMP_C);
    assign val_o   = maj3(s_a, s_b, rx_i);
    assign noisy_o = split3(s_a, s_b, rx_i);

endmodule

// File: rtl/osr_rx_framer.sv
module osr_rx_framer
    import osr_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              tick_i,
    input  logic              rx_i,
    input  logic              par_en_i,
    input  logic              par_odd_i,
    input  logic              two_stop_i,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output frm_err_t          err_o
);
    localparam int CW = $clog2(OSR + 1);
    localparam int BW = $clog2(DATA_W);
    localparam logic [CW-1:0] LAST_SMP = CW'(OSR);
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

    rx_state_e         state;
    logic [CW-1:0]     cnt, smp;
    logic [BW-1:0]     bidx;
    logic [DATA_W-1:0] shreg;
    frm_err_t          acc, err_upd;
    logic              bit_rdy, bit_val, bit_noisy, finish, abort, in_bit;

    assign smp    = cnt + 1'b1;
    assign in_bit = (state != ST_IDLE);

    osr_rx_voter #(.OSR(OSR), .CW(CW)) u_vote (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick_i && in_bit),
        .smp_i   (smp),
        .rx_i    (rx_i),
        .rdy_o   (bit_rdy),
        .val_o   (bit_val),
        .noisy_o (bit_noisy)
    );

    always_comb begin
        err_upd = acc;
        if (bit_rdy) begin
            err_upd.noise = acc.noise | bit_noisy;
            if (state == ST_PAR)
                err_upd.parity = bit_val ^ (^shreg) ^ par_odd_i;
            if (state == ST_STOP1 || state == ST_STOP2)
                err_upd.framing = acc.framing | ~bit_val;
        end
        finish = bit_rdy && ((state == ST_STOP1 && !two_stop_i) || state == ST_STOP2);
        abort  = bit_rdy && (state == ST_START) && bit_val;
    end

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            bidx   <= '0;
            shreg  <= '0;
            acc    <= '0;
            done_o <= 1'b0;
            data_o <= '0;
            err_o  <= '0;
        end else begin
            done_o <= 1'b0;
            if (tick_i) begin
                if (state == ST_IDLE) begin
                    if (!rx_i) begin
                        state <= ST_START;
                        cnt   <= CW'(1);
                        bidx  <= '0;
                        acc   <= '0;
                    end
                end else if (abort) begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end else if (finish) begin
                    done_o <= 1'b1;
                    data_o <= shreg;
                    err_o  <= err_upd;
                    state  <= ST_IDLE;
                    cnt    <= '0;
                end else begin
                    acc <= err_upd;
                    if (bit_rdy && state == ST_DATA)
                        shreg <= {bit_val, shreg[DATA_W-1:1]};
                    if (smp == LAST_SMP) begin
                        cnt <= '0;
                        case (state)
                            ST_START: state <= ST_DATA;
                            ST_DATA: begin
                                if (bidx == LAST_BIT)
                                    state <= par_en_i ? ST_PAR : ST_STOP1;
                                else
                                    bidx <= bidx + 1'b1;
                            end
                            ST_PAR:   state <= ST_STOP1;
                            ST_STOP1: state <= ST_STOP2;
                            default:  state <= ST_IDLE;
                        endcase
                    end else begin
                        cnt <= smp;
                    end
                end
            end
        end
    end

    // R8: a disabled receiver sits idle and never completes a frame
    a_r8_disable_idle: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (state == ST_IDLE && !done_o));

    // R9: a start bit voted high sends the receiver back to idle
    a_r9_false_start: assert property (@(posedge clk) disable iff (rst)
        (en_i && bit_rdy && state == ST_START && bit_val) |=> (state == ST_IDLE && !done_o));

endmodule

// File: rtl/osr_rx_hold.sv
module osr_rx_hold
    import osr_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done_i,
    input  logic [DATA_W-1:0] data_i,
    input  frm_err_t          err_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] data_o,
    output logic              full_o,
    output logic              noise_o,
    output logic              par_o,
    output logic              frm_o,
    output logic              ovr_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_o  <= '0;
            full_o  <= 1'b0;
            noise_o <= 1'b0;
            par_o   <= 1'b0;
            frm_o   <= 1'b0;
            ovr_o   <= 1'b0;
        end else if (done_i && (!full_o || rd_i)) begin
            data_o  <= data_i;
            full_o  <= 1'b1;
            noise_o <= err_i.noise;
            par_o   <= err_i.parity;
            frm_o   <= err_i.framing;
            ovr_o   <= 1'b0;
        end else if (done_i) begin
            ovr_o <= 1'b1;
        end else if (rd_i) begin
            full_o  <= 1'b0;
            noise_o <= 1'b0;
            par_o   <= 1'b0;
            frm_o   <= 1'b0;
            ovr_o   <= 1'b0;
        end
    end

    a_r5_load_sets_full: assert property (@(posedge clk) disable iff (rst)
        (done_i && (!full_o || rd_i)) |=> (full_o && data_o == $past(data_i) && !ovr_o));

    a_r6_overrun_keeps: assert property (@(posedge clk) disable iff (rst)
        (done_i && full_o && !rd_i) |=> (ovr_o && full_o && $stable(data_o)));

    a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !done_i) |=> (!full_o && !ovr_o && !noise_o && !par_o && !frm_o));

endmodule

// File: rtl/osr_uart_rx.sv
module osr_uart_rx
    import osr_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_i,
    input  logic              tick16_i,
    input  logic              rx_en_i,
    input  logic              par_en_i,
    input  logic              par_odd_i,
    input  logic              two_stop_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] data_o,
    output logic              full_o,
    output logic              noise_err_o,
    output logic              par_err_o,
    output logic              frame_err_o,
    output logic              ovr_err_o
);
    logic              fr_done;
    logic [DATA_W-1:0] fr_data;
    frm_err_t          fr_err;

    osr_rx_framer #(.DATA_W(DATA_W), .OSR(OSR)) u_framer (
        .clk        (clk),
        .rst        (rst),
        .en_i       (rx_en_i),
        .tick_i     (tick16_i),
        .rx_i       (rx_i),
        .par_en_i   (par_en_i),
        .par_odd_i  (par_odd_i),
        .two_stop_i (two_stop_i),
        .done_o     (fr_done),
        .data_o     (fr_data),
        .err_o      (fr_err)
    );

    osr_rx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .done_i  (fr_done),
        .data_i  (fr_data),
        .err_i   (fr_err),
        .rd_i    (rd_i),
        .data_o  (data_o),
        .full_o  (full_o),
        .noise_o (noise_err_o),
        .par_o   (par_err_o),
        .frm_o   (frame_err_o),
        .ovr_o   (ovr_err_o)
    );

endmodule

// File: tb/osr_uart_rx_test.sv
module osr_uart_rx_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx = 1'b1;
    logic       tick = 1'b0;
    logic       en = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       two_stop = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] data_o;
    logic       full_o, noise_o, par_o, frm_o, ovr_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [1:0] tdiv = '0;

    typedef struct {
        logic [7:0] d;
        logic       n, p, f, o;
        string      tag;
    } exp_t;

    exp_t q[$];

    always #2 clk = ~clk;

    osr_uart_rx uut (
        .clk(clk), .rst(rst), .rx_i(rx), .tick16_i(tick), .rx_en_i(en),
        .par_en_i(par_en), .par_odd_i(par_odd), .two_stop_i(two_stop), .rd_i(rd),
        .data_o(data_o), .full_o(full_o), .noise_err_o(noise_o),
        .par_err_o(par_o), .frame_err_o(frm_o), .ovr_err_o(ovr_o)
    );

    // baud tick: one cycle in three
    always_ff @(posedge clk) begin
        if (rst) begin
            tdiv <= '0;
            tick <= 1'b0;
        end else begin
            tdiv <= (tdiv == 2'd2) ? 2'd0 : tdiv + 2'd1;
            tick <= (tdiv == 2'd2);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog expired act=%0d exp<=150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    task automatic drive_sample(input logic v);
        do @(negedge clk); while (tick !== 1'b1);
        rx = v;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive_sample(1'b1);
    endtask

    // monitor side: pop the oldest expected item and compare with the outputs
    task automatic compare_front();
        exp_t e;
        if (q.size() == 0) begin
            chk("R5 scoreboard empty on read", 1, 0);
            return;
        end
        e = q.pop_front();
        chk({e.tag, " R5 full"}, int'(full_o), 1);
        chk({e.tag, " R5 data"}, int'(data_o), int'(e.d));
        chk({e.tag, " R2 noise"}, int'(noise_o), int'(e.n));
        chk({e.tag, " R3 parity"}, int'(par_o), int'(e.p));
        chk({e.tag, " R4 framing"}, int'(frm_o), int'(e.f));
        chk({e.tag, " R6 overrun"}, int'(ovr_o), int'(e.o));
    endtask

    task automatic send_bit(input logic v, input int gpos, input bit mid_rd, input logic [7:0] newd);
        for (int s = 1; s <= 16; s++) begin
            drive_sample((s == gpos) ? ~v : v);
            if (mid_rd && s == 9) begin
                @(negedge clk);
                compare_front();
                rd = 1'b1;
                @(negedge clk);
                rd = 1'b0;
                chk("R7 coincident load data", int'(data_o), int'(newd));
                chk("R7 coincident full kept", int'(full_o), 1);
                chk("R7 coincident no overrun", int'(ovr_o), 0);
            end
        end
    endtask

    // gbit: 0 start, 1..8 data, 9 parity, 10 last stop, -1 none
    task automatic send_frame(input string tag, input logic [7:0] d, input logic pe,
                              input logic po, input logic ts, input int gbit, input int gpos,
                              input logic flip_par, input logic bad_stop, input bit store,
                              input bit mid_rd);
        exp_t e;
        logic pbit;
        par_en = pe;
        par_odd = po;
        two_stop = ts;
        pbit = (^d) ^ po ^ flip_par;
        if (store) begin
            e.d = d;
            e.n = (gbit >= 0) && (gpos >= 7) && (gpos <= 9);
            e.p = pe & flip_par;
            e.f = bad_stop;
            e.o = 1'b0;
            e.tag = tag;
            q.push_back(e);
        end else begin
            q[q.size() - 1].o = 1'b1;
        end
        send_bit(1'b0, (gbit == 0) ? gpos : 0, 1'b0, d);
        for (int i = 0; i < 8; i++) send_bit(d[i], (gbit == i + 1) ? gpos : 0, 1'b0, d);
        if (pe) send_bit(pbit, (gbit == 9) ? gpos : 0, 1'b0, d);
        if (ts) send_bit(1'b1, 0, 1'b0, d);
        send_bit(~bad_stop, (gbit == 10) ? gpos : 0, mid_rd, d);
        idle(3);
    endtask

    task automatic read_chk();
        @(negedge clk);
        compare_front();
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        chk("R7 read clears full", int'(full_o), 0);
        chk("R7 read clears flags", int'({noise_o, par_o, frm_o, ovr_o}), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 reset data", int'(data_o), 0);
        chk("R10 reset full", int'(full_o), 0);
        chk("R10 reset flags", int'({noise_o, par_o, frm_o, ovr_o}), 0);
        en = 1'b1;
        idle(5);

        // R1 R5: clean frame, LSB first
        send_frame("R1 clean", 8'hA5, 0, 0, 0, -1, 0, 0, 0, 1, 0);
        read_chk();

        // R1 R2: single glitch at sample 8 of data bit 3 is outvoted but flagged
        send_frame("R1 glitch s8", 8'h3C, 0, 0, 0, 4, 8, 0, 0, 1, 0);
        read_chk();

        // R1: glitch at sample 6 is outside the window, no effect at all
        send_frame("R1 glitch s6", 8'hC3, 0, 0, 0, 2, 6, 0, 0, 1, 0);
        read_chk();

        // R2: glitch on the start bit
        send_frame("R2 start noise", 8'h81, 0, 0, 0, 0, 7, 0, 0, 1, 0);
        read_chk();

        // R2 R4: glitch at sample 9 of the stop bit, stop still votes 1
        send_frame("R2 stop noise", 8'h42, 0, 0, 0, 10, 9, 0, 0, 1, 0);
        read_chk();

        // R3: even parity correct, odd parity correct, odd parity wrong
        send_frame("R3 even ok", 8'h17, 1, 0, 0, -1, 0, 0, 0, 1, 0);
        read_chk();
        send_frame("R3 odd ok", 8'h17, 1, 1, 0, -1, 0, 0, 0, 1, 0);
        read_chk();
        send_frame("R3 odd bad", 8'hF0, 1, 1, 0, -1, 0, 1, 0, 1, 0);
        read_chk();

        // R4: broken single stop, broken second of two stops
        send_frame("R4 one stop bad", 8'h5A, 0, 0, 0, -1, 0, 0, 1, 1, 0);
        idle(16);
        read_chk();
        send_frame("R4 two stop bad", 8'h69, 1, 0, 1, -1, 0, 0, 1, 1, 0);
        idle(16);
        read_chk();
        send_frame("R4 two stop ok", 8'h96, 0, 0, 1, -1, 0, 0, 0, 1, 0);
        read_chk();

        // R6: second frame arrives before the read
        send_frame("R6 first kept", 8'h11, 0, 0, 0, -1, 0, 0, 0, 1, 0);
        send_frame("R6 dropped", 8'hEE, 0, 0, 0, -1, 0, 0, 0, 0, 0);
        read_chk();

        // R7: read strobe in the cycle of completion
        send_frame("R7 old word", 8'h24, 0, 0, 0, -1, 0, 0, 0, 1, 0);
        send_frame("R7 new word", 8'hDB, 0, 0, 0, -1, 0, 0, 0, 1, 1);
        read_chk();

        // R8: disable in the middle of a frame
        par_en = 1'b0;
        two_stop = 1'b0;
        send_bit(1'b0, 0, 1'b0, 8'h00);
        for (int i = 0; i < 3; i++) send_bit(1'b0, 0, 1'b0, 8'h00);
        @(negedge clk);
        en = 1'b0;
        repeat (6) @(negedge clk);
        rx = 1'b1;
        en = 1'b1;
        idle(40);
        chk("R8 abandoned frame not stored", int'(full_o), 0);
        send_frame("R8 recovery", 8'h7E, 0, 0, 0, -1, 0, 0, 0, 1, 0);
        read_chk();

        // R9: start pulse too short, high over samples 7..9
        for (int s = 1; s <= 16; s++) drive_sample(s <= 5 ? 1'b0 : 1'b1);
        idle(40);
        chk("R9 false start not stored", int'(full_o), 0);
        chk("R9 false start no flags", int'({noise_o, par_o, frm_o, ovr_o}), 0);
        send_frame("R9 recovery", 8'hB2, 0, 0, 0, -1, 0, 0, 0, 1, 0);
        read_chk();

        chk("R5 scoreboard drained", q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule